// File: doc/BRIEF.md
# Fractional-Divider PWM Time Base

This block produces one shared time base for a group of PWM channels. A tick-select input picks one of two tick enables: a fast one or a reference one. A fractional divider then turns the chosen ticks into count enables. The divisor is a fixed-point number with 10 integer bits and 8 fractional bits. The divider waits either the integer number of ticks or one tick more, so the average spacing of count enables equals the full divisor.

Each count enable advances a counter. A 5-bit resolution field sets the counter range to a power of two, and the counter is at most 20 bits wide. When the counter wraps to zero, the block raises a one-cycle overflow strobe for the channels and sets a sticky interrupt bit. The host can pause the counter, hold it at zero, and read its live value. Everything runs in a single clock domain.

The default build copies the divisor and the resolution into working registers only when the host asks for it, and only at a safe moment. This keeps a period from being cut short part way through. A build parameter removes this gating, so that the working values follow the inputs one clock later.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the overflow strobe is low and the interrupt bit is clear. The working divisor is 1.0 and the working resolution is 0.
- R2: With `tick_sel` = 1 only `fast_tick` feeds the divider; with `tick_sel` = 0 only `ref_tick` feeds it.
- R3: Bits [17:8] of the divisor are the integer part N and bits [7:0] are the fraction F. With F = 0 and N ≥ 1, the count advances once every N source ticks, and it changes at the clock edge that samples the Nth tick.
- R4: Each divider period lasts N ticks, or N+1 ticks when the previous period ended with a carry out of an 8-bit accumulator. At the end of every period the accumulator adds F. It starts at 0, so the first period after a clear lasts N ticks.
- R5: The counter runs from 0 to 2^res − 1 and then returns to 0. A count that is already at or above the limit returns to 0 on the next count enable. A resolution of 0 keeps the count at 0.
- R6: `ovf` is high for exactly the clock cycle after each wrap, which is the cycle in which the count first reads 0.
- R7: While `pause` is high, both the count and the divider progress hold still. Ticks that arrive during the pause are discarded.
- R8: While `cnt_clr` is high, the count, the divider progress and its accumulator are all zero, and `ovf` is low. `cnt_clr` takes priority over `pause`.
- R9: `irq_raw` is set by each wrap and stays set until `irq_clr`. A wrap in the same cycle as `irq_clr` leaves the bit set. `irq` = `irq_raw` AND `irq_ena`.
- R10: With GATED_UPDATE = 1, changes on `cfg_div` and `cfg_res` have no effect until `para_up` is pulsed. The new values are then taken at the next wrap, or at once if `cnt_clr` is high.
- R11: With GATED_UPDATE = 0, the working divisor and resolution follow `cfg_div` and `cfg_res` one clock later, without any `para_up`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| fast_tick | input | 1 | Fast tick enable |
| ref_tick | input | 1 | Reference tick enable |
| tick_sel | input | 1 | Source select: 1 = fast, 0 = reference |
| pause | input | 1 | Freezes the counter and the divider |
| cnt_clr | input | 1 | Holds the counter and the divider at zero |
| cfg_res | input | 5 | Counter resolution in bits; values above 20 act as 20 |
| cfg_div | input | 18 | Divisor, 10.8 fixed point |
| para_up | input | 1 | Strobe that requests the new divisor and resolution to be taken |
| irq_ena | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the interrupt bit |
| count | output | 20 | Live counter value |
| ovf | output | 1 | One-cycle wrap strobe |
| irq_raw | output | 1 | Sticky wrap flag |
| irq | output | 1 | Enabled interrupt |

## Verification
The assertions assume that `pause`, `cnt_clr` and the configuration inputs are levels that change only between clock edges. They also assume that `para_up` and `irq_clr` are sampled as plain levels, with no edge detection. The pause and clear checks rely on there being no hidden path by which a tick could move the count on while either level is high.

The stimulus changes every input just after a rising edge. It raises `para_up` either together with `cnt_clr` during setup, or for a single cycle during a run. It keeps the divisor integer at 1 or more, so every count enable comes from a real source tick.

// File: rtl/ftb_pkg.sv
`timescale 1ns/1ps
package ftb_pkg;
    localparam int CNT_W  = 20;
    localparam int RES_W  = 5;
    localparam int INT_W  = 10;
    localparam int FRAC_W = 8;
    localparam int DIV_W  = INT_W + FRAC_W;

    typedef struct packed {
        logic [INT_W-1:0]  tc;
        logic [FRAC_W-1:0] acc;
        logic              extra;
    } div_st_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_st_t;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [RES_W-1:0] res;
        logic             pend;
    } shd_st_t;
endpackage

// File: rtl/ftb_divider.sv
`timescale 1ns/1ps
module ftb_divider
    import ftb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             cen
);
    div_st_t s_d, s_q;
    logic [INT_W-1:0]  n_int;
    logic [FRAC_W-1:0] n_frac;
    logic [FRAC_W:0]   acc_sum;
    logic [INT_W:0]    tc_inc;
    logic [INT_W:0]    limit;

    always_comb begin
        n_int   = div[DIV_W-1:FRAC_W];
        n_frac  = div[FRAC_W-1:0];
        acc_sum = {1'b0, s_q.acc} + {1'b0, n_frac};
        tc_inc  = {1'b0, s_q.tc} + (INT_W+1)'(1);
        limit   = {1'b0, n_int} + (INT_W+1)'(s_q.extra);
        cen     = 1'b0;
        s_d     = s_q;
        if (clear) begin
            s_d = '0;
        end else if (tick && !hold) begin
            if (tc_inc >= limit) begin
                cen       = 1'b1;
                s_d.tc    = '0;
                s_d.acc   = acc_sum[FRAC_W-1:0];
                s_d.extra = acc_sum[FRAC_W];
            end else begin
                s_d.tc = tc_inc[INT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q == '0)); // R8
    AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !clear) |=> $stable(s_q)); // R7
endmodule

// File: rtl/ftb_counter.sv
`timescale 1ns/1ps
module ftb_counter
    import ftb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cen,
    input  logic             clear,
    input  logic [RES_W-1:0] res,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf,
    output logic             wrap
);
    localparam logic [RES_W-1:0] RES_MAX = RES_W'(CNT_W);

    cnt_st_t s_d, s_q;
    logic [RES_W-1:0] res_eff;
    logic [CNT_W:0]   max_v;

    always_comb begin
        res_eff = (res > RES_MAX) ? RES_MAX : res;
        max_v   = ((CNT_W+1)'(1) << res_eff) - (CNT_W+1)'(1);
        wrap    = cen && !clear && ({1'b0, s_q.cnt} >= max_v);
        s_d     = s_q;
        s_d.ovf = wrap;
        if (clear) begin
            s_d.cnt = '0;
        end else if (cen) begin
            s_d.cnt = wrap ? '0 : s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign ovf = s_q.ovf;

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ovf |-> (s_q.cnt == '0)); // R6
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == $past(s_q.cnt)) || (s_q.cnt == $past(s_q.cnt) + CNT_W'(1))
        || (s_q.cnt == '0)); // R5
endmodule

// File: rtl/ftb_irq.sv
`timescale 1ns/1ps
module ftb_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ena,
    output logic raw,
    output logic st
);
    logic raw_d, raw_q;

    always_comb begin
        raw_d = set | (raw_q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= raw_d;
    end

    assign raw = raw_q;
    assign st  = raw_q & ena;

    AST_IRQ_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> raw_q); // R9
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !raw_q); // R9
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase
    import ftb_pkg::*;
#(
    parameter bit GATED_UPDATE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fast_tick,
    input  logic        ref_tick,
    input  logic        tick_sel,
    input  logic        pause,
    input  logic        cnt_clr,
    input  logic [4:0]  cfg_res,
    input  logic [17:0] cfg_div,
    input  logic        para_up,
    input  logic        irq_ena,
    input  logic        irq_clr,
    output logic [19:0] count,
    output logic        ovf,
    output logic        irq_raw,
    output logic        irq
);
    localparam shd_st_t SHD_RST = '{div: DIV_W'(1) << FRAC_W, res: '0, pend: 1'b0};

    shd_st_t sh_d, sh_q;
    logic src_tick, cen, wrap, load, pend_next;

    assign src_tick = tick_sel ? fast_tick : ref_tick;

    generate
        if (GATED_UPDATE) begin : g_gated
            assign load      = (sh_q.pend | para_up) & (wrap | cnt_clr);
            assign pend_next = (sh_q.pend | para_up) & ~load;
        end else begin : g_direct
            assign load      = 1'b1;
            assign pend_next = para_up;
        end
    endgenerate

    always_comb begin
        sh_d      = sh_q;
        sh_d.pend = pend_next;
        if (load) begin
            sh_d.div = cfg_div;
            sh_d.res = cfg_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= SHD_RST;
        else        sh_q <= sh_d;
    end

    ftb_divider u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (src_tick),
        .hold  (pause),
        .clear (cnt_clr),
        .div   (sh_q.div),
        .cen   (cen)
    );

    ftb_counter u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .cen   (cen),
        .clear (cnt_clr),
        .res   (sh_q.res),
        .cnt   (count),
        .ovf   (ovf),
        .wrap  (wrap)
    );

    ftb_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wrap),
        .clr   (irq_clr),
        .ena   (irq_ena),
        .raw   (irq_raw),
        .st    (irq)
    );

    AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !cnt_clr) |=> $stable(count)); // R7
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (count == '0 && !ovf)); // R8
    AST_OVF_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> irq_raw); // R9

    generate
        if (GATED_UPDATE) begin : g_chk_gated
            AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
                !(sh_q.pend || para_up) |=> ($stable(sh_q.div) && $stable(sh_q.res))); // R10
        end else begin : g_chk_direct
            AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
                (sh_q.res == $past(cfg_res)) && (sh_q.div == $past(cfg_div))); // R11
        end
    endgenerate
endmodule

// File: tb/pwm_timebase_test.sv
`timescale 1ns/1ps
module pwm_timebase_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_tick = 1'b0, ref_tick = 1'b0, tick_sel = 1'b1;
    logic        pause = 1'b0, cnt_clr = 1'b0, para_up = 1'b0;
    logic [4:0]  cfg_res = '0;
    logic [17:0] cfg_div = 18'h100;
    logic        irq_ena = 1'b0, irq_clr = 1'b0;
    logic [19:0] count, count_f;
    logic        ovf, irq_raw, irq, ovf_f, irq_raw_f, irq_f;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    int m_tc, m_acc, m_ext, m_cnt, m_res, m_div, m_pend, m_ovf, m_raw;

    always #4 clk = ~clk;

    pwm_timebase uut (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .ref_tick(ref_tick),
        .tick_sel(tick_sel), .pause(pause), .cnt_clr(cnt_clr), .cfg_res(cfg_res),
        .cfg_div(cfg_div), .para_up(para_up), .irq_ena(irq_ena), .irq_clr(irq_clr),
        .count(count), .ovf(ovf), .irq_raw(irq_raw), .irq(irq));

    pwm_timebase #(.GATED_UPDATE(1'b0)) uut_fast (
        .clk(clk), .rst_n(rst_n), .fast_tick(fast_tick), .ref_tick(ref_tick),
        .tick_sel(tick_sel), .pause(pause), .cnt_clr(cnt_clr), .cfg_res(cfg_res),
        .cfg_div(cfg_div), .para_up(para_up), .irq_ena(irq_ena), .irq_clr(irq_clr),
        .count(count_f), .ovf(ovf_f), .irq_raw(irq_raw_f), .irq(irq_f));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model of the gated variant, advanced once per clock edge.
    task automatic model_edge();
        int src, fire, wrap, maxv, rs, p, sum;
        src = tick_sel ? int'(fast_tick) : int'(ref_tick);
        fire = 0; wrap = 0;
        if (cnt_clr) begin
            m_tc = 0; m_acc = 0; m_ext = 0; m_cnt = 0; m_ovf = 0;
        end else begin
            if (src != 0 && !pause) begin
                if (m_tc + 1 >= ((m_div >> 8) & 1023) + m_ext) begin
                    fire = 1;
                    sum = m_acc + (m_div & 255);
                    m_tc = 0; m_acc = sum & 255; m_ext = sum >> 8;
                end else m_tc = m_tc + 1;
            end
            if (fire != 0) begin
                rs = (m_res > 20) ? 20 : m_res;
                maxv = (1 << rs) - 1;
                if (m_cnt >= maxv) begin m_cnt = 0; wrap = 1; end
                else m_cnt = m_cnt + 1;
            end
            m_ovf = wrap;
        end
        m_raw = (wrap != 0 || (m_raw != 0 && !irq_clr)) ? 1 : 0;
        p = (m_pend != 0 || para_up) ? 1 : 0;
        if (p != 0 && (wrap != 0 || cnt_clr)) begin
            m_res = int'(cfg_res); m_div = int'(cfg_div); m_pend = 0;
        end else m_pend = p;
    endtask

    task automatic cyc(input string tag);
        @(posedge clk); #1;
        model_edge();
        chk(tag, {11'b0, count, ovf}, {11'b0, m_cnt[19:0], m_ovf[0]});
    endtask

    task automatic setup(input int res, input int dv, input bit sel);
        cfg_res = res[4:0]; cfg_div = dv[17:0]; tick_sel = sel;
        fast_tick = 0; ref_tick = 0; pause = 0;
        cnt_clr = 1; para_up = 1;
        cyc("R8 setup");
        cnt_clr = 0; para_up = 0;
    endtask

    task automatic test_reset();
        m_tc = 0; m_acc = 0; m_ext = 0; m_cnt = 0; m_res = 0; m_div = 256;
        m_pend = 0; m_ovf = 0; m_raw = 0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        chk("R1 count", {12'b0, count}, 32'd0);
        chk("R1 ovf", {31'b0, ovf}, 32'd0);
        chk("R1 irq_raw", {31'b0, irq_raw}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        fast_tick = 1;
        cyc("R1 divisor 1.0 res 0");
        fast_tick = 0;
    endtask

    task automatic test_int_div();
        setup(3, 3 << 8, 1'b1);
        for (int i = 0; i < 30; i++) begin
            fast_tick = 1; ref_tick = (i % 2 == 0);
            cyc("R3 R5 R6 integer divide");
        end
    endtask

    task automatic test_tick_sel();
        setup(4, 1 << 8, 1'b0);
        for (int i = 0; i < 24; i++) begin
            fast_tick = 1; ref_tick = (i % 3 == 0);
            cyc("R2 reference source");
        end
        tick_sel = 1;
        for (int i = 0; i < 24; i++) begin
            ref_tick = 1; fast_tick = (i % 2 == 0);
            cyc("R2 fast source");
        end
    endtask

    task automatic test_frac();
        setup(5, 18'h280, 1'b1);
        for (int i = 0; i < 40; i++) begin
            fast_tick = 1; cyc("R4 fraction one half");
        end
        setup(5, 18'h1C0, 1'b1);
        for (int i = 0; i < 30; i++) begin
            fast_tick = (i % 4 != 3); cyc("R4 fraction three quarters");
        end
    endtask

    task automatic test_range();
        setup(0, 1 << 8, 1'b1);
        for (int i = 0; i < 6; i++) begin
            fast_tick = 1; cyc("R5 R6 zero resolution");
        end
        setup(2, 1 << 8, 1'b1);
        for (int i = 0; i < 12; i++) begin
            fast_tick = 1; cyc("R5 R6 two-bit range");
        end
    endtask

    task automatic test_pause();
        logic [19:0] held;
        setup(4, 18'h240, 1'b1);
        fast_tick = 1;
        for (int i = 0; i < 5; i++) cyc("R7 before pause");
        pause = 1;
        held = count;
        for (int i = 0; i < 6; i++) cyc("R7 paused");
        chk("R7 count held", {12'b0, count}, {12'b0, held});
        pause = 0;
        for (int i = 0; i < 10; i++) cyc("R7 resumed");
    endtask

    task automatic test_clr();
        setup(4, 2 << 8, 1'b1);
        fast_tick = 1;
        for (int i = 0; i < 7; i++) cyc("R8 run");
        pause = 1; cnt_clr = 1;
        cyc("R8 clear over pause");
        chk("R8 count zero", {12'b0, count}, 32'd0);
        pause = 0;
        cyc("R8 clear held");
        cnt_clr = 0;
        for (int i = 0; i < 8; i++) cyc("R8 restart");
    endtask

    task automatic test_irq();
        setup(0, 1 << 8, 1'b1);
        irq_ena = 0; irq_clr = 1;
        cyc("R9 flush");
        irq_clr = 0;
        chk("R9 raw cleared", {31'b0, irq_raw}, 32'd0);
        fast_tick = 1; cyc("R9 wrap");
        chk("R9 raw set", {31'b0, irq_raw}, 32'd1);
        chk("R9 masked", {31'b0, irq}, 32'd0);
        fast_tick = 0; irq_ena = 1; cyc("R9 idle");
        chk("R9 enabled", {31'b0, irq}, 32'd1);
        fast_tick = 1; irq_clr = 1; cyc("R9 set with clear");
        chk("R9 set wins", {31'b0, irq_raw}, 32'd1);
        fast_tick = 0; cyc("R9 clear");
        chk("R9 cleared raw", {31'b0, irq_raw}, 32'd0);
        chk("R9 cleared irq", {31'b0, irq}, 32'd0);
        irq_clr = 0; irq_ena = 0;
    endtask

    task automatic test_gated();
        setup(2, 1 << 8, 1'b1);
        fast_tick = 1;
        for (int i = 0; i < 3; i++) cyc("R10 run");
        cfg_res = 5'd3; cfg_div = 18'h200;
        for (int i = 0; i < 6; i++) cyc("R10 ignored without request");
        para_up = 1; cyc("R10 request");
        para_up = 0;
        for (int i = 0; i < 20; i++) cyc("R10 applied at wrap");
    endtask

    task automatic test_direct();
        setup(3, 1 << 8, 1'b1);
        fast_tick = 1;
        cyc("R11 run"); cyc("R11 run");
        chk("R11 direct count", {12'b0, count_f}, 32'd2);
        fast_tick = 0; cfg_res = 5'd1;
        cyc("R11 change");
        fast_tick = 1;
        cyc("R10 gated keeps range");
        chk("R11 direct wrap count", {12'b0, count_f}, 32'd0);
        chk("R11 direct wrap strobe", {31'b0, ovf_f}, 32'd1);
        chk("R10 gated count", {12'b0, count}, 32'd3);
        fast_tick = 0;
    endtask

    initial begin
        test_reset();
        test_int_div();
        test_tick_sel();
        test_frac();
        test_range();
        test_pause();
        test_clr();
        test_irq();
        test_gated();
        test_direct();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule